// File: doc/BRIEF.md
# Rename Readiness Capture with Writeback Override

This block sits in the rename stage of an out-of-order core. For each renamed instruction it translates two logical source registers into physical tags through a small logical-to-physical map. It looks up a per-physical-register ready bit and a stored result for each tag. From these it builds the source fields of the outgoing reorder-buffer entry: a tag, a ready flag and a value per source. A source found ready carries its value. A source found not ready must wait for a later writeback whose tag matches it.

The hazard this block closes is a writeback that lands between the ready-bit lookup and the entry write. The ready table is read before it is written within a cycle. Each source tag is therefore compared against the three writeback buses of the same cycle. A valid match forces the source ready and takes the bus data. The same comparison keeps running while a finished entry waits at the output for the consumer. An instruction therefore never waits for a wakeup that has already happened.

Renames arrive on a valid/ready stream, and entries leave on a second valid/ready stream through a single output register. A rename is taken only when `ren_valid` and `ren_ready` are both high. `ren_ready` is high when the output register is empty or is being drained in the same cycle, so back-pressure from `ent_ready` stalls rename immediately and nothing is dropped. Writebacks cannot be stalled and are taken every cycle. Each writeback sets the ready bit of its tag and stores its data. Allocating a destination tag clears the ready bit of that tag.

Top module: `rename_ready_capture`

## Requirements
- R1: After reset the output entry is empty, `ren_ready` is 1, each logical register n maps to physical tag n, and every physical tag is ready with value 0.
- R2: A source whose tag's ready bit is set, and which has no same-cycle writeback match, appears in the entry with ready 1 and the value last written back to that tag.
- R3: A source whose tag's ready bit is clear, and which has no same-cycle writeback match, appears with ready 0.
- R4: If a valid writeback tag equals a source's physical tag in the cycle the rename is taken, that source appears with ready 1 and the writeback data.
- R5: When both sources carry the same physical tag, each takes the same-cycle override independently.
- R6: While the entry is held (`ent_valid` 1, `ent_ready` 0), a valid writeback matching a not-ready source sets its ready flag and value one cycle later. A source that is already ready keeps its value unchanged.
- R7: A writeback bus with its valid bit low neither overrides a source nor sets a ready bit, even when its tag matches.
- R8: A taken rename with `ren_dst_en` 1 maps `ren_ldst` to `ren_pdst` and clears that tag's ready bit. Its own sources are translated through the mapping in force before this update.
- R9: A valid writeback sets its tag's ready bit and stores its data for later renames. If the same tag is allocated in the same cycle, the allocation wins and the bit ends clear.
- R10: `ren_ready` = !`ent_valid` | `ent_ready`. While the entry is held, its tags stay stable and a new rename is not taken. When the entry is consumed and no new rename is taken, `ent_valid` falls on that edge.
- R11: Writeback bus 0 is bits [TAG_W-1:0] of `wb_tag` and [DATA_W-1:0] of `wb_data`, with bus k at slice k. Each of the three buses can override a source. At most one valid bus may carry a given tag in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Rename request can be taken |
| ren_lsrc_a | input | LREG_W (3) | Logical index of source A |
| ren_lsrc_b | input | LREG_W (3) | Logical index of source B |
| ren_ldst | input | LREG_W (3) | Logical destination index |
| ren_pdst | input | TAG_W (5) | Newly allocated physical destination tag |
| ren_dst_en | input | 1 | The instruction writes a destination |
| wb_valid | input | NUM_WB (3) | Per-bus writeback valid |
| wb_tag | input | NUM_WB*TAG_W (15) | Writeback tags, bus k at slice k |
| wb_data | input | NUM_WB*DATA_W (48) | Writeback results, bus k at slice k |
| ent_valid | output | 1 | Entry present at output |
| ent_ready | input | 1 | Consumer takes the entry |
| ent_ptag_a | output | TAG_W (5) | Physical tag of source A |
| ent_rdy_a | output | 1 | Source A ready |
| ent_val_a | output | DATA_W (16) | Source A value |
| ent_ptag_b | output | TAG_W (5) | Physical tag of source B |
| ent_rdy_b | output | 1 | Source B ready |
| ent_val_b | output | DATA_W (16) | Source B value |

## Verification
A wrong ready bit shows up at the ports on the next rename that reads that tag. An entry then leaves not ready when its data was already produced, which is the silent deadlock case, or ready with a stale value. Either error appears one cycle after the rename is taken. A broken map shows as a wrong `ent_ptag_a`/`ent_ptag_b` on the first rename after the bad write. A missed override, whether at capture or during a hold, is visible on `ent_rdy_a`/`ent_rdy_b` in the cycle after the writeback. The bench therefore pairs every ready-bit change with a rename that reads that tag straight afterwards.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  localparam int LREG_W_DEF = 3;
  localparam int TAG_W_DEF  = 5;
  localparam int DATA_W_DEF = 16;
  localparam int NUM_WB_DEF = 3;
  localparam int NUM_SRC    = 2;
endpackage

// File: rtl/rrc_alias_map.sv
module rrc_alias_map #(
  parameter int LREG_W  = rrc_pkg::LREG_W_DEF,
  parameter int TAG_W   = rrc_pkg::TAG_W_DEF,
  parameter int NUM_SRC = rrc_pkg::NUM_SRC
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_SRC-1:0][LREG_W-1:0]   rd_idx,
  output logic [NUM_SRC-1:0][TAG_W-1:0]    rd_tag,
  input  logic                             wr_en,
  input  logic [LREG_W-1:0]                wr_idx,
  input  logic [TAG_W-1:0]                 wr_tag
);
  localparam int NUM_LREG = 1 << LREG_W;

  logic [NUM_LREG-1:0][TAG_W-1:0] map_q;

  // one register per logical index; identity mapping out of reset (R1)
  for (genvar l = 0; l < NUM_LREG; l++) begin : g_lreg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_q[l] <= TAG_W'(l);
      end else if (wr_en && wr_idx == LREG_W'(l)) begin
        map_q[l] <= wr_tag;
      end
    end
  end

  // reads see the mapping before this cycle's update (R8)
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_rd
    assign rd_tag[s] = map_q[rd_idx[s]];
  end
endmodule

// File: rtl/rrc_ready_table.sv
module rrc_ready_table #(
  parameter int TAG_W   = rrc_pkg::TAG_W_DEF,
  parameter int DATA_W  = rrc_pkg::DATA_W_DEF,
  parameter int NUM_WB  = rrc_pkg::NUM_WB_DEF,
  parameter int NUM_SRC = rrc_pkg::NUM_SRC
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0][TAG_W-1:0]   rd_tag,
  output logic [NUM_SRC-1:0]              rd_rdy,
  output logic [NUM_SRC-1:0][DATA_W-1:0]  rd_val,
  input  logic [NUM_WB-1:0]               wb_valid,
  input  logic [NUM_WB-1:0][TAG_W-1:0]    wb_tag,
  input  logic [NUM_WB-1:0][DATA_W-1:0]   wb_data,
  input  logic                            alloc_en,
  input  logic [TAG_W-1:0]                alloc_tag
);
  localparam int NUM_PREG = 1 << TAG_W;

  logic [NUM_PREG-1:0]             rdy_q;
  logic [NUM_PREG-1:0][DATA_W-1:0] val_q;

  for (genvar p = 0; p < NUM_PREG; p++) begin : g_preg
    logic              set_hit;
    logic [DATA_W-1:0] set_data;
    logic              clr_hit;

    // lowest-numbered valid bus supplies the data
    always_comb begin
      set_hit  = 1'b0;
      set_data = '0;
      for (int b = NUM_WB - 1; b >= 0; b--) begin
        if (wb_valid[b] && wb_tag[b] == TAG_W'(p)) begin
          set_hit  = 1'b1;
          set_data = wb_data[b];
        end
      end
    end

    assign clr_hit = alloc_en && alloc_tag == TAG_W'(p);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdy_q[p] <= 1'b1;
        val_q[p] <= '0;
      end else begin
        if (set_hit) begin
          val_q[p] <= set_data;
        end
        // allocation beats a same-cycle writeback (R9)
        if (clr_hit) begin
          rdy_q[p] <= 1'b0;
        end else if (set_hit) begin
          rdy_q[p] <= 1'b1;
        end
      end
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_rd
    assign rd_rdy[s] = rdy_q[rd_tag[s]];
    assign rd_val[s] = val_q[rd_tag[s]];
  end

  // two valid buses carrying one tag in a cycle is illegal
  logic wb_dup;
  always_comb begin
    wb_dup = 1'b0;
    for (int i = 0; i < NUM_WB; i++) begin
      for (int j = i + 1; j < NUM_WB; j++) begin
        if (wb_valid[i] && wb_valid[j] && wb_tag[i] == wb_tag[j]) wb_dup = 1'b1;
      end
    end
  end

  p_wb_tag_unique_r11: assert property (@(posedge clk) disable iff (!rst_n) !wb_dup);

  p_alloc_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> !rdy_q[$past(alloc_tag)]);

  for (genvar b = 0; b < NUM_WB; b++) begin : g_wb_chk
    p_wb_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid[b] && !(alloc_en && alloc_tag == wb_tag[b]))
        |=> (rdy_q[$past(wb_tag[b])] && val_q[$past(wb_tag[b])] == $past(wb_data[b])));
  end
endmodule

// File: rtl/rrc_wb_match.sv
module rrc_wb_match #(
  parameter int TAG_W  = rrc_pkg::TAG_W_DEF,
  parameter int DATA_W = rrc_pkg::DATA_W_DEF,
  parameter int NUM_WB = rrc_pkg::NUM_WB_DEF
) (
  input  logic [TAG_W-1:0]               tag,
  input  logic [NUM_WB-1:0]              wb_valid,
  input  logic [NUM_WB-1:0][TAG_W-1:0]   wb_tag,
  input  logic [NUM_WB-1:0][DATA_W-1:0]  wb_data,
  output logic                           hit,
  output logic [DATA_W-1:0]              hit_data
);
  logic [NUM_WB-1:0] hit_vec;

  for (genvar b = 0; b < NUM_WB; b++) begin : g_cmp
    assign hit_vec[b] = wb_valid[b] && wb_tag[b] == tag; // gated by valid (R7)
  end

  always_comb begin
    hit      = |hit_vec;
    hit_data = '0;
    for (int b = NUM_WB - 1; b >= 0; b--) begin
      if (hit_vec[b]) hit_data = wb_data[b];
    end
  end
endmodule

// File: rtl/rrc_entry_stage.sv
module rrc_entry_stage #(
  parameter int TAG_W   = rrc_pkg::TAG_W_DEF,
  parameter int DATA_W  = rrc_pkg::DATA_W_DEF,
  parameter int NUM_SRC = rrc_pkg::NUM_SRC
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            accept,
  input  logic [NUM_SRC-1:0][TAG_W-1:0]   cap_tag,
  input  logic [NUM_SRC-1:0]              cap_rdy,
  input  logic [NUM_SRC-1:0][DATA_W-1:0]  cap_val,
  input  logic [NUM_SRC-1:0]              rn_hit,
  input  logic [NUM_SRC-1:0][DATA_W-1:0]  rn_data,
  input  logic [NUM_SRC-1:0]              hd_hit,
  input  logic [NUM_SRC-1:0][DATA_W-1:0]  hd_data,
  input  logic                            ent_ready,
  output logic                            ent_valid,
  output logic [NUM_SRC-1:0][TAG_W-1:0]   ent_tag,
  output logic [NUM_SRC-1:0]              ent_rdy,
  output logic [NUM_SRC-1:0][DATA_W-1:0]  ent_val
);
  logic held;
  assign held = ent_valid && !ent_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid <= 1'b0;
    end else if (accept) begin
      ent_valid <= 1'b1;
    end else if (ent_ready) begin
      ent_valid <= 1'b0;
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_tag[s] <= '0;
        ent_rdy[s] <= 1'b0;
        ent_val[s] <= '0;
      end else if (accept) begin
        // same-cycle writeback overrides the table (R4, R5)
        ent_tag[s] <= cap_tag[s];
        ent_rdy[s] <= cap_rdy[s] || rn_hit[s];
        ent_val[s] <= rn_hit[s] ? rn_data[s] : cap_val[s];
      end else if (held && !ent_rdy[s] && hd_hit[s]) begin
        // late wakeup while waiting at the output (R6)
        ent_rdy[s] <= 1'b1;
        ent_val[s] <= hd_data[s];
      end
    end

    p_override_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && rn_hit[s]) |=> (ent_rdy[s] && ent_val[s] == $past(rn_data[s])));

    p_held_wakeup_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !ent_rdy[s] && hd_hit[s]) |=> (ent_rdy[s] && ent_val[s] == $past(hd_data[s])));

    p_held_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (held && ent_rdy[s]) |=> (ent_rdy[s] && $stable(ent_val[s])));

    p_held_tag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      held |=> $stable(ent_tag[s]));
  end

  p_held_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> ent_valid);

  p_no_take_when_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !accept);
endmodule

// File: rtl/rename_ready_capture.sv
module rename_ready_capture #(
  parameter int LREG_W = rrc_pkg::LREG_W_DEF,
  parameter int TAG_W  = rrc_pkg::TAG_W_DEF,
  parameter int DATA_W = rrc_pkg::DATA_W_DEF,
  parameter int NUM_WB = rrc_pkg::NUM_WB_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ren_valid,
  output logic                     ren_ready,
  input  logic [LREG_W-1:0]        ren_lsrc_a,
  input  logic [LREG_W-1:0]        ren_lsrc_b,
  input  logic [LREG_W-1:0]        ren_ldst,
  input  logic [TAG_W-1:0]         ren_pdst,
  input  logic                     ren_dst_en,
  input  logic [NUM_WB-1:0]        wb_valid,
  input  logic [NUM_WB*TAG_W-1:0]  wb_tag,
  input  logic [NUM_WB*DATA_W-1:0] wb_data,
  output logic                     ent_valid,
  input  logic                     ent_ready,
  output logic [TAG_W-1:0]         ent_ptag_a,
  output logic                     ent_rdy_a,
  output logic [DATA_W-1:0]        ent_val_a,
  output logic [TAG_W-1:0]         ent_ptag_b,
  output logic                     ent_rdy_b,
  output logic [DATA_W-1:0]        ent_val_b
);
  localparam int NSRC = rrc_pkg::NUM_SRC;

  logic [NUM_WB-1:0][TAG_W-1:0]  wb_tag_v;
  logic [NUM_WB-1:0][DATA_W-1:0] wb_data_v;
  assign wb_tag_v  = wb_tag;
  assign wb_data_v = wb_data;

  logic [NSRC-1:0][LREG_W-1:0] lsrc;
  assign lsrc = {ren_lsrc_b, ren_lsrc_a};

  logic accept;
  assign ren_ready = !ent_valid || ent_ready;
  assign accept    = ren_valid && ren_ready;

  logic [NSRC-1:0][TAG_W-1:0]  map_tag;
  logic [NSRC-1:0]             tbl_rdy;
  logic [NSRC-1:0][DATA_W-1:0] tbl_val;
  logic [NSRC-1:0]             rn_hit, hd_hit;
  logic [NSRC-1:0][DATA_W-1:0] rn_data, hd_data;
  logic [NSRC-1:0][TAG_W-1:0]  ent_tag;
  logic [NSRC-1:0]             ent_rdy;
  logic [NSRC-1:0][DATA_W-1:0] ent_val;

  rrc_alias_map #(.LREG_W(LREG_W), .TAG_W(TAG_W), .NUM_SRC(NSRC)) u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (lsrc),
    .rd_tag (map_tag),
    .wr_en  (accept && ren_dst_en),
    .wr_idx (ren_ldst),
    .wr_tag (ren_pdst)
  );

  rrc_ready_table #(.TAG_W(TAG_W), .DATA_W(DATA_W), .NUM_WB(NUM_WB), .NUM_SRC(NSRC)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_tag    (map_tag),
    .rd_rdy    (tbl_rdy),
    .rd_val    (tbl_val),
    .wb_valid  (wb_valid),
    .wb_tag    (wb_tag_v),
    .wb_data   (wb_data_v),
    .alloc_en  (accept && ren_dst_en),
    .alloc_tag (ren_pdst)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_snoop
    // compare at capture time against the freshly read tag
    rrc_wb_match #(.TAG_W(TAG_W), .DATA_W(DATA_W), .NUM_WB(NUM_WB)) u_rn (
      .tag      (map_tag[s]),
      .wb_valid (wb_valid),
      .wb_tag   (wb_tag_v),
      .wb_data  (wb_data_v),
      .hit      (rn_hit[s]),
      .hit_data (rn_data[s])
    );
    // compare while the entry waits at the output
    rrc_wb_match #(.TAG_W(TAG_W), .DATA_W(DATA_W), .NUM_WB(NUM_WB)) u_hd (
      .tag      (ent_tag[s]),
      .wb_valid (wb_valid),
      .wb_tag   (wb_tag_v),
      .wb_data  (wb_data_v),
      .hit      (hd_hit[s]),
      .hit_data (hd_data[s])
    );
  end

  rrc_entry_stage #(.TAG_W(TAG_W), .DATA_W(DATA_W), .NUM_SRC(NSRC)) u_ent (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .cap_tag   (map_tag),
    .cap_rdy   (tbl_rdy),
    .cap_val   (tbl_val),
    .rn_hit    (rn_hit),
    .rn_data   (rn_data),
    .hd_hit    (hd_hit),
    .hd_data   (hd_data),
    .ent_ready (ent_ready),
    .ent_valid (ent_valid),
    .ent_tag   (ent_tag),
    .ent_rdy   (ent_rdy),
    .ent_val   (ent_val)
  );

  assign ent_ptag_a = ent_tag[0];
  assign ent_rdy_a  = ent_rdy[0];
  assign ent_val_a  = ent_val[0];
  assign ent_ptag_b = ent_tag[1];
  assign ent_rdy_b  = ent_rdy[1];
  assign ent_val_b  = ent_val[1];

  p_ready_rule_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && !ent_ready) |-> !ren_ready);
endmodule

// File: tb/test_rename_ready_capture.sv
module test_rename_ready_capture;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 3, TW = 5, DW = 16, NB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ren_valid = 1'b0, ren_ready, ren_dst_en = 1'b0;
  logic [LW-1:0] ren_lsrc_a = '0, ren_lsrc_b = '0, ren_ldst = '0;
  logic [TW-1:0] ren_pdst = '0;
  logic [NB-1:0] wb_valid = '0;
  logic [NB*TW-1:0] wb_tag = '0;
  logic [NB*DW-1:0] wb_data = '0;
  logic ent_valid, ent_ready = 1'b1;
  logic [TW-1:0] ent_ptag_a, ent_ptag_b;
  logic ent_rdy_a, ent_rdy_b;
  logic [DW-1:0] ent_val_a, ent_val_b;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rename_ready_capture i_rename_ready_capture (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_lsrc_a(ren_lsrc_a), .ren_lsrc_b(ren_lsrc_b), .ren_ldst(ren_ldst),
    .ren_pdst(ren_pdst), .ren_dst_en(ren_dst_en), .wb_valid(wb_valid),
    .wb_tag(wb_tag), .wb_data(wb_data), .ent_valid(ent_valid), .ent_ready(ent_ready),
    .ent_ptag_a(ent_ptag_a), .ent_rdy_a(ent_rdy_a), .ent_val_a(ent_val_a),
    .ent_ptag_b(ent_ptag_b), .ent_rdy_b(ent_rdy_b), .ent_val_b(ent_val_b)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model built from the requirements
  logic [TW-1:0] map_m [8];
  logic          rdy_m [32];
  logic [DW-1:0] val_m [32];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_src(input logic [LW-1:0] ls, input logic [NB-1:0] wv,
                           input logic [NB*TW-1:0] wt, input logic [NB*DW-1:0] wd,
                           output logic [TW-1:0] tg, output logic r, output logic [DW-1:0] v);
    logic hit = 1'b0;
    tg = map_m[ls];
    v  = val_m[tg];
    for (int b = NB - 1; b >= 0; b--) begin
      if (wv[b] && wt[b*TW +: TW] == tg) begin hit = 1'b1; v = wd[b*DW +: DW]; end
    end
    r = rdy_m[tg] | hit;
  endtask

  task automatic model_update(input logic take, input logic den, input logic [LW-1:0] ld,
                              input logic [TW-1:0] pd, input logic [NB-1:0] wv,
                              input logic [NB*TW-1:0] wt, input logic [NB*DW-1:0] wd);
    for (int b = NB - 1; b >= 0; b--) begin
      if (wv[b]) begin rdy_m[wt[b*TW +: TW]] = 1'b1; val_m[wt[b*TW +: TW]] = wd[b*DW +: DW]; end
    end
    if (take && den) begin rdy_m[pd] = 1'b0; map_m[ld] = pd; end
  endtask

  task automatic rename_chk(input string req, input logic [LW-1:0] la, input logic [LW-1:0] lb,
                            input logic den, input logic [LW-1:0] ld, input logic [TW-1:0] pd,
                            input logic [NB-1:0] wv, input logic [NB*TW-1:0] wt,
                            input logic [NB*DW-1:0] wd);
    logic [TW-1:0] ta, tb;
    logic ra, rb;
    logic [DW-1:0] va, vb;
    @(negedge clk);
    ren_valid = 1'b1; ren_lsrc_a = la; ren_lsrc_b = lb; ren_dst_en = den;
    ren_ldst = ld; ren_pdst = pd; wb_valid = wv; wb_tag = wt; wb_data = wd;
    model_src(la, wv, wt, wd, ta, ra, va);
    model_src(lb, wv, wt, wd, tb, rb, vb);
    @(posedge clk);
    model_update(1'b1, den, ld, pd, wv, wt, wd);
    @(negedge clk);
    ren_valid = 1'b0; ren_dst_en = 1'b0; wb_valid = '0;
    chk(req, "ent_valid", 32'(ent_valid), 32'd1);
    chk(req, "ptag_a", 32'(ent_ptag_a), 32'(ta));
    chk(req, "rdy_a", 32'(ent_rdy_a), 32'(ra));
    chk(req, "val_a", 32'(ent_val_a), 32'(va));
    chk(req, "ptag_b", 32'(ent_ptag_b), 32'(tb));
    chk(req, "rdy_b", 32'(ent_rdy_b), 32'(rb));
    chk(req, "val_b", 32'(ent_val_b), 32'(vb));
  endtask

  task automatic wb_only(input logic [NB-1:0] wv, input logic [NB*TW-1:0] wt, input logic [NB*DW-1:0] wd);
    @(negedge clk);
    wb_valid = wv; wb_tag = wt; wb_data = wd;
    @(posedge clk);
    model_update(1'b0, 1'b0, '0, '0, wv, wt, wd);
    @(negedge clk);
    wb_valid = '0;
  endtask

  task automatic t_reset;
    chk("R1", "ent_valid after reset", 32'(ent_valid), 32'd0);
    chk("R1", "ren_ready after reset", 32'(ren_ready), 32'd1);
    rename_chk("R1", 3'd3, 3'd5, 1'b0, 3'd0, 5'd0, 3'b000, '0, '0);
  endtask

  task automatic t_ready_path;
    wb_only(3'b001, {10'd0, 5'd3}, {32'd0, 16'h1234});
    rename_chk("R2", 3'd3, 3'd3, 1'b0, 3'd0, 5'd0, 3'b000, '0, '0);
  endtask

  task automatic t_not_ready;
    // source A reads old mapping of logical 2 while 2 is remapped (R8)
    rename_chk("R8", 3'd2, 3'd0, 1'b1, 3'd2, 5'd20, 3'b000, '0, '0);
    rename_chk("R3", 3'd2, 3'd1, 1'b0, 3'd0, 5'd0, 3'b000, '0, '0);
  endtask

  task automatic t_override;
    rename_chk("R4", 3'd2, 3'd0, 1'b0, 3'd0, 5'd0, 3'b001, {10'd0, 5'd20}, {32'd0, 16'hA5A5});
    rename_chk("R9", 3'd2, 3'd2, 1'b0, 3'd0, 5'd0, 3'b000, '0, '0);
  endtask

  task automatic t_both_same;
    rename_chk("R8", 3'd0, 3'd0, 1'b1, 3'd4, 5'd21, 3'b000, '0, '0);
    rename_chk("R5", 3'd4, 3'd4, 1'b0, 3'd0, 5'd0, 3'b010, {5'd0, 5'd21, 5'd0}, {16'd0, 16'h0F0F, 16'd0});
  endtask

  task automatic t_bus2;
    rename_chk("R8", 3'd0, 3'd0, 1'b1, 3'd5, 5'd22, 3'b000, '0, '0);
    rename_chk("R11", 3'd5, 3'd1, 1'b0, 3'd0, 5'd0, 3'b101,
               {5'd22, 5'd0, 5'd3}, {16'h2222, 16'd0, 16'h3333});
  endtask

  task automatic t_invalid_bus;
    rename_chk("R8", 3'd0, 3'd0, 1'b1, 3'd6, 5'd23, 3'b000, '0, '0);
    rename_chk("R7", 3'd6, 3'd6, 1'b0, 3'd0, 5'd0, 3'b000, {10'd0, 5'd23}, {32'd0, 16'h9999});
    rename_chk("R7", 3'd6, 3'd0, 1'b0, 3'd0, 5'd0, 3'b000, '0, '0);
  endtask

  task automatic t_alloc_vs_wb;
    rename_chk("R9", 3'd0, 3'd0, 1'b1, 3'd7, 5'd24, 3'b001, {10'd0, 5'd24}, {32'd0, 16'h4444});
    rename_chk("R9", 3'd7, 3'd7, 1'b0, 3'd0, 5'd0, 3'b000, '0, '0);
  endtask

  task automatic t_held;
    logic [DW-1:0] old_b;
    @(negedge clk);
    ent_ready = 1'b0; ren_valid = 1'b1; ren_lsrc_a = 3'd6; ren_lsrc_b = 3'd1; ren_dst_en = 1'b0;
    old_b = val_m[map_m[1]];
    @(negedge clk);
    chk("R10", "ren_ready while held", 32'(ren_ready), 32'd0);
    chk("R10", "ent_valid held", 32'(ent_valid), 32'd1);
    chk("R3", "held rdy_a before wakeup", 32'(ent_rdy_a), 32'd0);
    // a rejected rename plus two writebacks while held
    ren_lsrc_a = 3'd3; ren_lsrc_b = 3'd3;
    wb_valid = 3'b011; wb_tag = {5'd0, 5'd1, 5'd23}; wb_data = {16'd0, 16'h7777, 16'hBEEF};
    @(posedge clk);
    model_update(1'b0, 1'b0, '0, '0, 3'b011, {5'd0, 5'd1, 5'd23}, {16'd0, 16'h7777, 16'hBEEF});
    @(negedge clk);
    ren_valid = 1'b0; wb_valid = '0;
    chk("R10", "held ptag_a unchanged", 32'(ent_ptag_a), 32'd23);
    chk("R10", "held ptag_b unchanged", 32'(ent_ptag_b), 32'(map_m[1]));
    chk("R6", "late wakeup rdy_a", 32'(ent_rdy_a), 32'd1);
    chk("R6", "late wakeup val_a", 32'(ent_val_a), 32'hBEEF);
    chk("R6", "ready src keeps val_b", 32'(ent_val_b), 32'(old_b));
    chk("R6", "ready src keeps rdy_b", 32'(ent_rdy_b), 32'd1);
    ent_ready = 1'b1;
    @(negedge clk);
    chk("R10", "ent_valid drops after drain", 32'(ent_valid), 32'd0);
    rename_chk("R6", 3'd6, 3'd1, 1'b0, 3'd0, 5'd0, 3'b000, '0, '0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) map_m[i] = TW'(i);
    for (int i = 0; i < 32; i++) begin rdy_m[i] = 1'b1; val_m[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ready_path();
    t_not_ready();
    t_override();
    t_both_same();
    t_bus2();
    t_invalid_bus();
    t_alloc_vs_wb();
    t_held();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - errors, checks);
      $finish;
    end
  end
endmodule